// File: doc/BRIEF.md
# Prefix-Extended Byte Instruction Decoder

This block accepts a stream of one-byte instructions over a valid/ready handshake and turns each one into a decoded instruction. The upper nibble of a byte selects a function and the lower nibble supplies four bits of data. The data nibbles are collected in a 32-bit operand register. Prefix bytes emit nothing. Instead, they shift the collected value up by one nibble so that the next byte can add four more bits. This lets short chains of bytes build operands of any width up to the full register.

A byte that is not a prefix completes an instruction. If it carries one of the direct function codes, the block emits that code together with the full operand. If it carries the operate code, the block emits the collected operand as an extended operation number, with a flag that marks it as such. The operand register clears after every completed instruction. A negative prefix complements the collected value before it shifts it, so negative operands need no extra bytes.

The decoded result sits in an output register until the consumer takes it. While that register is full and not being drained, the byte input is stalled.

Top module: `pfx_byte_decoder`

## Requirements
- R1: After synchronous reset, `dec_valid` is 0, `byte_ready` is 1 and the operand register is zero, so the first direct byte `0xFN` style instruction reports an operand equal to its own nibble.
- R2: A byte is split into function code = bits 7:4 and data nibble = bits 3:0; a direct function with no prefix before it reports `dec_func` = bits 7:4 and `dec_operand` = bits 3:0.
- R3: Function code 0x2 (positive prefix) places its nibble in bits 3:0 of the operand register and then shifts the register left by 4, so 0x2A 0x2B 0x7C gives function 7 with operand 0xABC.
- R4: Function code 0x6 (negative prefix) places its nibble, complements the whole register and then shifts it left by 4, so 0x60 0x13 gives operand 0xFFFFFFF3 and 0x61 0x02 gives 0xFFFFFFE2.
- R5: Function code 0xF (operate) reports `dec_is_ext` = 1, `dec_func` = 0xF and the collected operand as the extended opcode, so 0x21 0xF6 gives extended opcode 0x16.
- R6: Every non-prefix byte clears the operand register, so the next instruction sees only its own nibble and the prefixes that follow.
- R7: Prefix chains reach the full 32-bit width, and bits shifted past bit 31 are discarded: seven positive prefixes 1..7 followed by 0x38 give 0x12345678.
- R8: The decoded result appears on the outputs in the cycle after its byte is accepted. `dec_valid` is raised only for non-prefix bytes, and each accepted byte takes one cycle.
- R9: While `dec_valid` is 1 and `dec_ready` is 0, the decoded outputs hold steady and `byte_ready` is 0, so no byte is consumed.
- R10: A cycle with `byte_valid` low consumes nothing, whatever `byte_in` holds, and leaves the operand register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_valid | input | 1 | An instruction byte is offered |
| byte_in | input | 8 | Instruction byte: function in bits 7:4, data in bits 3:0 |
| byte_ready | output | 1 | The block takes the offered byte in this cycle |
| dec_valid | output | 1 | A decoded instruction is held on the outputs |
| dec_ready | input | 1 | The consumer takes the decoded instruction |
| dec_is_ext | output | 1 | 1 for an operate instruction (extended opcode) |
| dec_func | output | 4 | Function code of the completed instruction |
| dec_operand | output | 32 | Operand, or extended opcode when `dec_is_ext` is 1 |

## Verification
The hardest case to reach is a long prefix chain that is interrupted by backpressure. Here the operand register must keep its partial value while a completed result waits at the output and the next byte is stalled. The stimulus holds `dec_ready` low right after an instruction completes, keeps offering the next byte for several cycles, and then releases it. Chains of seven and eight prefixes, including all-ones nibbles, drive the register to its width limit and past it. A behavioural model in the bench tracks every cycle, including idle cycles that carry prefix-like junk on `byte_in`.

// File: rtl/pfx_dec_pkg.sv
package pfx_dec_pkg;

   // Role of a function code in the decoder
   typedef enum logic [1:0] {
      CLS_DIRECT  = 2'd0,
      CLS_PFX_POS = 2'd1,
      CLS_PFX_NEG = 2'd2,
      CLS_OPERATE = 2'd3
   } fclass_e;

   function automatic logic is_prefix(input fclass_e c);
      return (c == CLS_PFX_POS) || (c == CLS_PFX_NEG);
   endfunction

endpackage

// File: rtl/pfx_fclass.sv
module pfx_fclass
   import pfx_dec_pkg::*;
#(
   parameter int FC_W   = 4,
   parameter int FC_POS = 2,
   parameter int FC_NEG = 6,
   parameter int FC_OPR = 15,
   parameter bit NEG_EN = 1'b1
) (
   input  logic [FC_W-1:0] fc,
   output fclass_e         cls
);

   localparam logic [FC_W-1:0] K_POS = FC_POS[FC_W-1:0];
   localparam logic [FC_W-1:0] K_NEG = FC_NEG[FC_W-1:0];
   localparam logic [FC_W-1:0] K_OPR = FC_OPR[FC_W-1:0];

   generate
      if (NEG_EN) begin : g_with_neg
         always_comb begin
            if (fc == K_POS)      cls = CLS_PFX_POS;
            else if (fc == K_NEG) cls = CLS_PFX_NEG;
            else if (fc == K_OPR) cls = CLS_OPERATE;
            else                  cls = CLS_DIRECT;
         end
      end else begin : g_pos_only
         always_comb begin
            if (fc == K_POS)      cls = CLS_PFX_POS;
            else if (fc == K_OPR) cls = CLS_OPERATE;
            else                  cls = CLS_DIRECT;
         end
      end
   endgenerate

endmodule

// File: rtl/pfx_opnd_acc.sv
module pfx_opnd_acc
   import pfx_dec_pkg::*;
#(
   parameter int OPR_W = 32,
   parameter int NIB_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   input  fclass_e          cls,
   input  logic [NIB_W-1:0] nib,
   output logic [OPR_W-1:0] loaded,
   output logic [OPR_W-1:0] oreg_q
);

   logic [OPR_W-1:0] oreg_nxt;

   // The nibble lands in the low bits of the held value
   assign loaded = {oreg_q[OPR_W-1:NIB_W], nib};

   always_comb begin
      case (cls)
         CLS_PFX_POS: oreg_nxt = loaded << NIB_W;
         CLS_PFX_NEG: oreg_nxt = (~loaded) << NIB_W;
         default:     oreg_nxt = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)       oreg_q <= '0;
      else if (step) oreg_q <= oreg_nxt;
   end

endmodule

// File: rtl/pfx_out_stage.sv
module pfx_out_stage #(
   parameter int OPR_W = 32,
   parameter int FC_W  = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             ld_ext,
   input  logic [FC_W-1:0]  ld_func,
   input  logic [OPR_W-1:0] ld_opnd,
   input  logic             take,
   output logic             q_valid,
   output logic             q_ext,
   output logic [FC_W-1:0]  q_func,
   output logic [OPR_W-1:0] q_opnd
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q_valid <= 1'b0;
         q_ext   <= 1'b0;
         q_func  <= '0;
         q_opnd  <= '0;
      end else if (load) begin
         q_valid <= 1'b1;
         q_ext   <= ld_ext;
         q_func  <= ld_func;
         q_opnd  <= ld_opnd;
      end else if (take) begin
         q_valid <= 1'b0;
      end
   end

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      (q_valid && !take) |=> (q_valid && $stable(q_opnd) && $stable(q_func) && $stable(q_ext))); // R9

endmodule

// File: rtl/pfx_byte_decoder.sv
module pfx_byte_decoder
   import pfx_dec_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int OPR_W  = 32,
   parameter int FC_POS = 2,
   parameter int FC_NEG = 6,
   parameter int FC_OPR = 15,
   parameter bit NEG_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                byte_valid,
   input  logic [BYTE_W-1:0]   byte_in,
   output logic                byte_ready,
   output logic                dec_valid,
   input  logic                dec_ready,
   output logic                dec_is_ext,
   output logic [BYTE_W/2-1:0] dec_func,
   output logic [OPR_W-1:0]    dec_operand
);

   localparam int NIB_W = BYTE_W / 2;
   localparam int FC_W  = BYTE_W - NIB_W;

   // Elaboration-time parameter checks
   generate
      if (BYTE_W % 2 != 0) begin : g_bad_byte
         $error("BYTE_W must be even");
      end
      if (OPR_W < BYTE_W || OPR_W % NIB_W != 0) begin : g_bad_opr
         $error("OPR_W must be a multiple of the nibble width and at least one byte");
      end
      if (FC_POS == FC_OPR || (NEG_EN && (FC_NEG == FC_POS || FC_NEG == FC_OPR))) begin : g_bad_codes
         $error("prefix and operate codes must differ");
      end
      if (FC_POS >= (1 << FC_W) || FC_NEG >= (1 << FC_W) || FC_OPR >= (1 << FC_W)) begin : g_bad_range
         $error("function codes must fit the function field");
      end
   endgenerate

   logic [FC_W-1:0]  fc;
   logic [NIB_W-1:0] nib;
   fclass_e          cls;
   logic             accept;
   logic             completes;
   logic [OPR_W-1:0] loaded;
   logic [OPR_W-1:0] oreg_q;

   assign fc  = byte_in[BYTE_W-1:NIB_W];
   assign nib = byte_in[NIB_W-1:0];

   assign byte_ready = !dec_valid || dec_ready;
   assign accept     = byte_valid && byte_ready;
   assign completes  = accept && !is_prefix(cls);

   pfx_fclass #(
      .FC_W   (FC_W),
      .FC_POS (FC_POS),
      .FC_NEG (FC_NEG),
      .FC_OPR (FC_OPR),
      .NEG_EN (NEG_EN)
   ) u_fclass (
      .fc  (fc),
      .cls (cls)
   );

   pfx_opnd_acc #(
      .OPR_W (OPR_W),
      .NIB_W (NIB_W)
   ) u_acc (
      .clk    (clk),
      .rst    (rst),
      .step   (accept),
      .cls    (cls),
      .nib    (nib),
      .loaded (loaded),
      .oreg_q (oreg_q)
   );

   pfx_out_stage #(
      .OPR_W (OPR_W),
      .FC_W  (FC_W)
   ) u_out (
      .clk     (clk),
      .rst     (rst),
      .load    (completes),
      .ld_ext  (cls == CLS_OPERATE),
      .ld_func (fc),
      .ld_opnd (loaded),
      .take    (dec_ready),
      .q_valid (dec_valid),
      .q_ext   (dec_is_ext),
      .q_func  (dec_func),
      .q_opnd  (dec_operand)
   );

   // Checks across the pieces
   AST_PFX_SILENT: assert property (@(posedge clk) disable iff (rst)
      (accept && is_prefix(cls)) |=> !dec_valid); // R8

   AST_EMIT_NEXT: assert property (@(posedge clk) disable iff (rst)
      completes |=> dec_valid); // R8

   AST_OREG_CLEARED: assert property (@(posedge clk) disable iff (rst)
      completes |=> (oreg_q == '0)); // R6

   AST_EXT_FUNC: assert property (@(posedge clk) disable iff (rst)
      (dec_valid && dec_is_ext) |-> (dec_func == FC_OPR[FC_W-1:0])); // R5

   AST_STALL_INPUT: assert property (@(posedge clk) disable iff (rst)
      (dec_valid && !dec_ready) |-> !byte_ready); // R9

   AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
      !byte_valid |=> $stable(oreg_q)); // R10

endmodule

// File: tb/tb_pfx_byte_decoder.sv
module tb_pfx_byte_decoder;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_in = 8'h00;
   logic        byte_ready;
   logic        dec_valid;
   logic        dec_ready = 1'b1;
   logic        dec_is_ext;
   logic [3:0]  dec_func;
   logic [31:0] dec_operand;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   pfx_byte_decoder dut (
      .clk         (clk),
      .rst         (rst),
      .byte_valid  (byte_valid),
      .byte_in     (byte_in),
      .byte_ready  (byte_ready),
      .dec_valid   (dec_valid),
      .dec_ready   (dec_ready),
      .dec_is_ext  (dec_is_ext),
      .dec_func    (dec_func),
      .dec_operand (dec_operand)
   );

   // Behavioural reference model, updated at each rising edge
   logic        m_valid = 1'b0;
   logic        m_ext   = 1'b0;
   logic [3:0]  m_func  = 4'h0;
   logic [31:0] m_opnd  = 32'h0;
   logic [31:0] m_acc   = 32'h0;

   always @(posedge clk) begin
      logic [31:0] withnib;
      logic        rdy;
      rdy     = !m_valid || dec_ready;
      withnib = (m_acc & 32'hFFFF_FFF0) | 32'(byte_in[3:0]);
      if (rst) begin
         m_valid <= 1'b0;
         m_acc   <= 32'h0;
      end else if (byte_valid && rdy) begin
         if (byte_in[7:4] == 4'h2) begin
            m_acc <= withnib * 16;
         end else if (byte_in[7:4] == 4'h6) begin
            m_acc <= (~withnib) * 16;
         end else begin
            m_acc   <= 32'h0;
            m_valid <= 1'b1;
            m_func  <= byte_in[7:4];
            m_ext   <= (byte_in[7:4] == 4'hF);
            m_opnd  <= withnib;
         end
      end else if (dec_ready) begin
         m_valid <= 1'b0;
      end
   end

   // Compare against the model on every clock (R8, R9)
   always @(negedge clk) begin
      if (!rst && !done) begin
         total++;
         if (dec_valid !== m_valid || byte_ready !== (!m_valid || dec_ready) ||
             (m_valid && (dec_func !== m_func || dec_is_ext !== m_ext || dec_operand !== m_opnd))) begin
            bad++;
            $display("FAIL R8 cycle %0d: got v=%b r=%b x=%b f=%h o=%h exp v=%b x=%b f=%h o=%h",
                     cyc, dec_valid, byte_ready, dec_is_ext, dec_func, dec_operand,
                     m_valid, m_ext, m_func, m_opnd);
         end
      end
   end

   // Watchdog
   always @(negedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: got cycle %0d expected finish before 20000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // Offer a byte until it is accepted; return at the negedge after acceptance
   task automatic send(input logic [7:0] b);
      bit took;
      @(negedge clk);
      #1;
      byte_valid = 1'b1;
      byte_in    = b;
      forever begin
         took = byte_ready;
         @(negedge clk);
         if (took) break;
      end
      #1;
      byte_valid = 1'b0;
      byte_in    = 8'h2F;   // idle junk
   endtask

   task automatic chk_out(input string req, input logic x, input logic [3:0] f, input logic [31:0] o);
      check(req, {31'b0, dec_valid, 31'b0, dec_is_ext}, {31'b0, 1'b1, 31'b0, x});
      check(req, {28'b0, dec_func, dec_operand}, {28'b0, f, o});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset valid", {63'b0, dec_valid}, 64'd0);
      check("R1 reset ready", {63'b0, byte_ready}, 64'd1);
      #1 rst = 1'b0;

      send(8'h45);                chk_out("R1 R2 direct", 1'b0, 4'h4, 32'h5);
      send(8'hD9);                chk_out("R2 direct", 1'b0, 4'hD, 32'h9);
      send(8'h21); check("R8 prefix silent", {63'b0, dec_valid}, 64'd0);
      send(8'hF6);                chk_out("R5 operate", 1'b1, 4'hF, 32'h16);
      send(8'h2A); send(8'h2B); send(8'h7C);
                                  chk_out("R3 prefix chain", 1'b0, 4'h7, 32'hABC);
      send(8'h60); send(8'h13);   chk_out("R4 neg prefix", 1'b0, 4'h1, 32'hFFFF_FFF3);
      send(8'h61); send(8'h02);   chk_out("R4 neg prefix 2", 1'b0, 4'h0, 32'hFFFF_FFE2);
      send(8'h83);                chk_out("R6 cleared", 1'b0, 4'h8, 32'h3);
      for (int i = 1; i <= 7; i++) send(8'h20 | 8'(i));
      send(8'h38);                chk_out("R7 full width", 1'b0, 4'h3, 32'h1234_5678);
      for (int i = 0; i < 8; i++) send(8'h2F);
      send(8'h10);                chk_out("R7 overflow discarded", 1'b0, 4'h1, 32'hFFFF_FFF0);
      send(8'h24); send(8'h2A); send(8'hFF);
                                  chk_out("R5 long ext", 1'b1, 4'hF, 32'h4AF);

      // R10: idle cycles with junk on the byte lines
      repeat (4) @(negedge clk);
      check("R10 idle no output", {63'b0, dec_valid}, 64'd0);
      send(8'h30);                chk_out("R10 oreg untouched", 1'b0, 4'h3, 32'h0);

      // R9: backpressure in the middle of a chain
      send(8'h25);
      #1 dec_ready = 1'b0;
      send(8'h46);                // completes; result waits
      fork
         send(8'h57);
         begin
            repeat (3) begin
               @(negedge clk);
               check("R9 stalled ready", {63'b0, byte_ready}, 64'd0);
               chk_out("R9 held", 1'b0, 4'h4, 32'h56);
            end
            #1 dec_ready = 1'b1;
         end
      join
      chk_out("R9 released", 1'b0, 4'h5, 32'h7);
      send(8'h2C); send(8'hE1);   chk_out("R6 R9 after stall", 1'b0, 4'hE, 32'hC1);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule